// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block collects single-cycle event pulses from up to sixteen device sources into a sticky status register. It combines that status with a per-source mask and drives one level-sensitive interrupt line towards a host processor. The host reaches the block through a plain synchronous register strobe interface with an address, write data and registered read data.

The mask can be written directly, or changed one bit at a time through a set alias and a clear alias. Writing a 0 to either alias has no effect. The status can be read in two ways: through a view that leaves it untouched, or through a view that empties the whole register as it is read. Single status bits are retired by writing ones to an acknowledge register.

The default bit roles are as follows:
- bit 10: command completion.
- bit 14: end of initialisation.
- bits 0 and 3: the two receive buffers.
- bits 1 and 2: transmit data and transmit transfer.
- bit 4: receive transfer.
- bits 5 and 6: mailbox events.
- bits 8 and 9: trace events.

The logic treats all bits alike.

Top module: `host_irq_aggregator`

## Requirements
- R1: After reset the mask reads 0x0001 at byte offset 0x00, the status reads 0 and `host_irq` is low. Bit 0 is therefore masked until the host clears it.
- R2: A write to offset 0x00 loads the mask from the low NUM_SRC bits of the write data. A read of offset 0x00 returns the mask, zero-extended.
- R3: A write to offset 0x04 sets every mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R4: A write to offset 0x08 clears every mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R5: A read of offset 0x0C returns the status and does not change it. Read data for any read is presented on `bus_rdata` from the clock edge that samples `bus_rd` and is held until the next read.
- R6: A read of offset 0x1C returns the status as it was before the access, and after that edge every status bit is 0.
- R7: A write to offset 0x14 clears each status bit whose write-data bit is 1. Bits written as 0 keep their state.
- R8: An event pulse on bit i sets status bit i at the next edge. This holds even when the same edge performs a clear-on-read or acknowledges bit i; the new event wins.
- R9: `host_irq` is a register that, one edge after any cycle, equals the OR over all bits of (status AND NOT mask) in that cycle.
- R10: Reads of offsets 0x04, 0x08, 0x14 and of any unmapped offset return 0. Writes to offsets 0x0C and 0x1C change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_pulse | input | NUM_SRC | Event pulses, one bit per source |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| host_irq | output | 1 | Level interrupt to the host |

## Verification
The bench builds the block with its default values: NUM_SRC = 16, DATA_W = 32 and ADDR_W = 5. With these values every source bit can be walked one at a time through the set alias, the clear alias, event latching, masking, acknowledge and the interrupt output. Each expected value is formed as a single-bit shift against a fixed background pattern. The 5-bit address covers all six mapped offsets as well as unmapped ones. The two race cases are driven in the same cycle: an event against a clear-on-read, and an event against an acknowledge of the same bit.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned OFS_MASK  = 'h00;
  localparam int unsigned OFS_MSET  = 'h04;
  localparam int unsigned OFS_MCLR  = 'h08;
  localparam int unsigned OFS_STND  = 'h0C;
  localparam int unsigned OFS_ACK   = 'h14;
  localparam int unsigned OFS_STCOR = 'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_MSET,
    SEL_MCLR,
    SEL_STND,
    SEL_ACK,
    SEL_STCOR
  } reg_sel_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == ADDR_W'(OFS_MASK))       sel = SEL_MASK;
    else if (addr == ADDR_W'(OFS_MSET))  sel = SEL_MSET;
    else if (addr == ADDR_W'(OFS_MCLR))  sel = SEL_MCLR;
    else if (addr == ADDR_W'(OFS_STND))  sel = SEL_STND;
    else if (addr == ADDR_W'(OFS_ACK))   sel = SEL_ACK;
    else if (addr == ADDR_W'(OFS_STCOR)) sel = SEL_STCOR;
    else                                 sel = SEL_NONE;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_agg_pkg::*;
#(
  parameter int          NUM_SRC  = 16,
  parameter logic [15:0] MASK_RST = 16'h0001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  reg_sel_e           sel,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] mask_q
);
  logic [NUM_SRC-1:0] mask_d;
  logic               mask_ce;

  always_comb begin
    mask_d  = mask_q;
    mask_ce = 1'b0;
    if (wr_en) begin
      unique case (sel)
        SEL_MASK: begin mask_d = wdata;            mask_ce = 1'b1; end
        SEL_MSET: begin mask_d = mask_q | wdata;   mask_ce = 1'b1; end
        SEL_MCLR: begin mask_d = mask_q & ~wdata;  mask_ce = 1'b1; end
        default:  begin mask_d = mask_q;           mask_ce = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= NUM_SRC'(MASK_RST);
    else if (mask_ce) mask_q <= mask_d;
  end

  // R3: ones are set, zeros leave their mask bits alone
  a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_MSET) |=>
      ((mask_q & $past(wdata)) == $past(wdata)) &&
      ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata))));

  // R4: ones are cleared, zeros leave their mask bits alone
  a_r4_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_MCLR) |=>
      ((mask_q & $past(wdata)) == '0) &&
      ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata))));

  // R10: writes elsewhere leave the mask unchanged
  a_r10_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (sel == SEL_MASK || sel == SEL_MSET || sel == SEL_MCLR)) |=> $stable(mask_q));
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               clr_all,
  input  logic               ack_en,
  input  logic [NUM_SRC-1:0] ack_bits,
  output logic [NUM_SRC-1:0] status_q
);
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] status_d;

  always_comb begin
    if (clr_all)     clr_vec = '1;
    else if (ack_en) clr_vec = ack_bits;
    else             clr_vec = '0;
    status_d = (status_q & ~clr_vec) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  // R8: a fresh event always lands, whatever clear happens at the same edge
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status_q & $past(evt)) == $past(evt)));

  // R6: clear-on-read with no new event leaves nothing set
  a_r6_cor_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && evt == '0) |=> (status_q == '0));

  // R5: with no event and no clear the status holds
  a_r5_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_all && !ack_en && evt == '0) |=> $stable(status_q));

  // R7: acknowledge clears exactly the bits written as one, absent events
  a_r7_ack_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && !clr_all && evt == '0) |=>
      (status_q == ($past(status_q) & ~$past(ack_bits))));
endmodule

// File: rtl/host_irq_aggregator.sv
module host_irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int          NUM_SRC  = 16,
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 5,
  parameter logic [15:0] MASK_RST = 16'h0001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_pulse,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               host_irq
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  // reset: asserted at once, released through two flops
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  reg_sel_e           sel;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] wdata_lo;
  logic               cor_rd;
  logic               ack_wr;
  logic [DATA_W-1:0]  rd_val;
  logic [DATA_W-1:0]  rdata_q;
  logic               irq_d, irq_q;

  assign wdata_lo = bus_wdata[NUM_SRC-1:0];

  generate
    if (PAD_W > 0) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^bus_wdata[DATA_W-1:NUM_SRC];
    end
  endgenerate

  irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  irq_mask_reg #(.NUM_SRC(NUM_SRC), .MASK_RST(MASK_RST)) u_mask (
    .clk    (clk),
    .rst_n  (rst_s),
    .wr_en  (bus_wr),
    .sel    (sel),
    .wdata  (wdata_lo),
    .mask_q (mask_q)
  );

  assign cor_rd = bus_rd && (sel == SEL_STCOR);
  assign ack_wr = bus_wr && (sel == SEL_ACK);

  irq_status_reg #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk      (clk),
    .rst_n    (rst_s),
    .evt      (evt_pulse),
    .clr_all  (cor_rd),
    .ack_en   (ack_wr),
    .ack_bits (wdata_lo),
    .status_q (status_q)
  );

  always_comb begin
    unique case (sel)
      SEL_MASK:            rd_val = DATA_W'(mask_q);
      SEL_STND, SEL_STCOR: rd_val = DATA_W'(status_q);
      default:             rd_val = '0;
    endcase
    irq_d = |(status_q & ~mask_q);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_rd) rdata_q <= rd_val;
      irq_q <= irq_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign host_irq  = irq_q;

  // R9: the line follows the previous cycle's unmasked status
  a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> (host_irq == |($past(status_q) & ~$past(mask_q))));

  // R6: clear-on-read returns the pre-access status
  a_r6_cor_value: assert property (@(posedge clk) disable iff (!rst_s)
    cor_rd |=> (bus_rdata == DATA_W'($past(status_q))));

  // R10: write-only and unmapped offsets read as zero
  a_r10_wo_zero: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_rd && (sel == SEL_MSET || sel == SEL_MCLR || sel == SEL_ACK || sel == SEL_NONE))
      |=> (bus_rdata == '0));

  // R5: read data holds between reads
  a_r5_rdata_hold: assert property (@(posedge clk) disable iff (!rst_s)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/sim_host_irq_aggregator.sv
module sim_host_irq_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int DW = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] evt_pulse;
  logic          bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          host_irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_irq_aggregator #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .host_irq(host_irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [NS-1:0] e);
    evt_pulse = e;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    rst_n = 1'b0; evt_pulse = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq low", DW'(host_irq), 0);
    rd(5'h00, d); chk("R1 mask reset", d, 32'h0001);
    rd(5'h0C, d); chk("R1 status reset", d, 0);
    // R1 bit 0 masked after reset
    pulse(16'h0001);
    @(negedge clk);
    chk("R1 bit0 masked", DW'(host_irq), 0);
    rd(5'h0C, d); chk("R1 bit0 latched", d, 32'h0001);
    rd(5'h1C, d); chk("R6 cor value", d, 32'h0001);
    rd(5'h0C, d); chk("R6 cor emptied", d, 0);

    // R2 direct mask
    wr(5'h00, 32'h0000A5A5); rd(5'h00, d); chk("R2 mask write", d, 32'hA5A5);
    wr(5'h00, 32'hFFFFFFFF); rd(5'h00, d); chk("R2 mask width", d, 32'hFFFF);

    // R3 / R4 walk every bit
    for (int i = 0; i < NS; i++) begin
      wr(5'h00, 32'h0F0F);
      wr(5'h04, DW'(1) << i);
      rd(5'h00, d); chk("R3 set alias", d, 32'h0F0F | (DW'(1) << i));
      wr(5'h08, DW'(1) << i);
      rd(5'h00, d); chk("R4 clr alias", d, 32'h0F0F & ~(DW'(1) << i) & 32'hFFFF);
    end

    // R5 R6 R7 R9 per bit
    for (int i = 0; i < NS; i++) begin
      int j = (i + 1) % NS;
      logic [DW-1:0] bi = DW'(1) << i;
      logic [DW-1:0] bj = DW'(1) << j;
      wr(5'h00, ~bi & 32'hFFFF);
      rd(5'h1C, d);
      pulse(NS'(bj));
      @(negedge clk);
      chk("R9 masked source", DW'(host_irq), 0);
      pulse(NS'(bi));
      chk("R9 latency", DW'(host_irq), 0);
      @(negedge clk);
      chk("R9 irq raised", DW'(host_irq), 1);
      rd(5'h0C, d); chk("R5 nd read", d, bi | bj);
      rd(5'h0C, d); chk("R5 nd unchanged", d, bi | bj);
      wr(5'h14, bi);
      rd(5'h0C, d); chk("R7 ack one bit", d, bj);
      chk("R9 irq dropped", DW'(host_irq), 0);
      rd(5'h1C, d); chk("R6 cor value", d, bj);
      rd(5'h0C, d); chk("R6 cor emptied", d, 0);
    end

    // R8 event against clear-on-read
    pulse(16'h0400);
    evt_pulse = 16'h0008; bus_rd = 1'b1; bus_addr = 5'h1C;
    @(negedge clk);
    evt_pulse = '0; bus_rd = 1'b0;
    chk("R8 cor returns old", bus_rdata, 32'h0400);
    rd(5'h0C, d); chk("R8 event beats cor", d, 32'h0008);
    // R8 event against acknowledge of the same bit
    pulse(16'h0020);
    evt_pulse = 16'h0020; bus_wr = 1'b1; bus_addr = 5'h14; bus_wdata = 32'h0028;
    @(negedge clk);
    evt_pulse = '0; bus_wr = 1'b0;
    rd(5'h0C, d); chk("R8 event beats ack", d, 32'h0020);
    rd(5'h1C, d);

    // R10 ignored writes and zero reads
    wr(5'h00, 32'h1234);
    wr(5'h0C, 32'hFFFF); rd(5'h0C, d); chk("R10 nd write ignored", d, 0);
    wr(5'h1C, 32'hFFFF); rd(5'h0C, d); chk("R10 cor write ignored", d, 0);
    rd(5'h00, d); chk("R10 mask untouched", d, 32'h1234);
    pulse(16'h0003);
    rd(5'h04, d); chk("R10 set alias reads 0", d, 0);
    rd(5'h08, d); chk("R10 clr alias reads 0", d, 0);
    rd(5'h14, d); chk("R10 ack reads 0", d, 0);
    rd(5'h10, d); chk("R10 unmapped reads 0", d, 0);
    rd(5'h0C, d); chk("R5 status kept", d, 32'h0003);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule